// File: doc/BRIEF.md
# HDLC Receive Address Screen

This block sits behind an HDLC receiver that has already removed flags and checked the frame check sequence. It watches the first octets of each received frame, works out how long the address field is, and decides whether the frame is meant for this station. The address is compared against two programmable station addresses, one for the local end and one for the remote end. A configurable all-ones global address and a promiscuous bypass are also available. When the frame ends, the block reports whether to keep it, and it counts frames that arrived damaged.

The byte stream arrives one octet per `in_valid` beat. `in_sof` marks the first octet and `in_eof` the last. On the last beat, `in_good` says whether the frame was octet aligned and had a good check sequence. The address decision appears on the `hit_*` outputs soon after the address field ends. A one-cycle `done_*` pulse gives the final verdict for each frame. Configuration is expected to stay constant while a frame is in progress.

Top module: `rx_addr_screen`

## Requirements
- R1: A frame whose last beat has `in_good`=0 produces, in the cycle after that beat, `done_valid`=1, `done_bad`=1 and `done_keep`=0, and `bad_count` rises by one in that same cycle.
- R2: With `cfg_ext_en`=0 the address is always one octet, whatever its bit 0 is (`hit_two`=0). It is compared with bits [7:0] of the programmed addresses.
- R3: With `cfg_ext_en`=1 and `cfg_ext_force`=0, a first octet with bit 0 = 1 is a one-octet address. A first octet with bit 0 = 0 makes the next octet part of the address (`hit_two`=1). A two-octet address matches when the first octet equals bits [7:0] and the second equals bits [15:8] of a programmed address.
- R4: With `cfg_ext_en`=1 and `cfg_ext_force`=1, the address is always two octets, regardless of bit 0 of the first octet.
- R5: An address equal to the local or the remote programmed address sets `hit_accept`=1. `hit_remote` is 1 only when the remote address matched and the local one did not.
- R6: With `cfg_global_en`=1, an address whose octets are all 0xFF is accepted with `hit_global`=1. With `cfg_global_en`=0 it is accepted only if it matches a programmed address.
- R7: With `cfg_promisc`=1, every good frame is kept (`done_keep`=1), including a frame that ends before its address is complete. `hit_remote` and `hit_global` stay 0 in this mode.
- R8: A good frame whose address matches nothing, and is not an enabled global address, ends with `done_valid`=1, `done_keep`=0 and `done_bad`=0, and `bad_count` does not change.
- R9: `bad_count` is 16 bits wide, holds at 0xFFFF once it gets there, and reads 0 after a synchronous reset.
- R10: The `hit_*` outputs update in the cycle after the last address octet. They hold until the beat that starts the next frame. `hit_valid` is 0 out of reset and while a second address octet is still awaited. `done_valid` is a one-cycle pulse in the cycle after each final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ext_en | input | 1 | Allow a two-octet address by the bit-0 extension rule |
| cfg_ext_force | input | 1 | With `cfg_ext_en`, always take two address octets |
| cfg_global_en | input | 1 | Accept the all-ones address |
| cfg_promisc | input | 1 | Bypass filtering; keep every good frame |
| cfg_local_addr | input | 16 | Local station address: [7:0] first octet, [15:8] second |
| cfg_remote_addr | input | 16 | Remote station address: [7:0] first octet, [15:8] second |
| in_valid | input | 1 | Octet beat strobe |
| in_data | input | 8 | Received octet |
| in_sof | input | 1 | First octet of a frame |
| in_eof | input | 1 | Last octet of a frame |
| in_good | input | 1 | On the last beat: aligned and check sequence correct |
| hit_valid | output | 1 | Address decision present for the current frame |
| hit_accept | output | 1 | Address accepted |
| hit_remote | output | 1 | Remote address matched (local did not) |
| hit_global | output | 1 | All-ones global address matched |
| hit_two | output | 1 | Address field was two octets |
| done_valid | output | 1 | One-cycle end-of-frame verdict strobe |
| done_keep | output | 1 | Frame is to be kept |
| done_bad | output | 1 | Frame was damaged and discarded |
| bad_count | output | 16 | Saturating damaged-frame count |

## Verification
The address decision is tested with several kinds of first octet. An even octet with extension off shows that the bit-0 rule is ignored. The same octet with extension on shows that the decision waits for a second octet. An odd octet under the force bit shows that forcing overrides the rule. Local-only, remote-only and tied addresses separate the match flag from the accept result. The all-ones octet is sent with the global enable both on and off, and a non-matching octet is sent with and without promiscuous mode. Damaged frames with a matching address show that a bad check sequence overrides a good address. A long run of damaged frames pushes the counter into saturation, and a reset afterwards shows that it clears.

// File: rtl/rx_addr_screen_pkg.sv
// Shared constants and types for the receive address screen.
package rx_addr_screen_pkg;

    // Octet width of the byte stream.
    localparam int OCT_W = 8;
    // Maximum address octets handled.
    localparam int ADDR_OCTS = 2;
    localparam int ADDR_W = OCT_W * ADDR_OCTS;

    // Mode bits gathered for the match logic.
    typedef struct packed {
        logic ext_en;
        logic ext_force;
        logic global_en;
        logic promisc;
    } scr_mode_t;

endpackage

// File: rtl/rx_addr_len_ctl.sv
// Address-length tracker.
// Follows the frame structure beat by beat and decides when the address
// field is complete (one or two octets). Assumes the mode bits are static
// during a frame; beats outside a frame (no sof seen) are ignored.
module rx_addr_len_ctl #(
    parameter int OCT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_vld,
    input  logic             beat_sof,
    input  logic             beat_eof,
    input  logic [OCT_W-1:0] beat_data,
    input  logic             ext_en,
    input  logic             ext_force,
    output logic             live_beat,
    output logic             live_eof,
    output logic             addr_done,
    output logic             addr_two,
    output logic [OCT_W-1:0] oct_lo,
    output logic [OCT_W-1:0] oct_hi
);

    logic             in_frame_q;
    logic             pend_q;
    logic [OCT_W-1:0] first_q;
    logic             first_beat;
    logic             need_more;

    // Decode the current beat against the tracked frame state.
    always_comb begin
        first_beat = beat_vld & beat_sof;
        live_beat  = beat_vld & (beat_sof | in_frame_q);
        live_eof   = live_beat & beat_eof;
        need_more  = ext_en & (ext_force | ~beat_data[0]);
        addr_done  = first_beat ? ~need_more : (live_beat & pend_q);
        addr_two   = ~first_beat;
        oct_lo     = first_beat ? beat_data : first_q;
        oct_hi     = beat_data;
    end

    // Track frame activity, pending second octet and the held first octet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            pend_q     <= 1'b0;
            first_q    <= '0;
        end else if (live_beat) begin
            in_frame_q <= ~beat_eof;
            pend_q     <= first_beat & need_more & ~beat_eof;
            if (first_beat) begin
                first_q <= beat_data;
            end
        end
    end

endmodule

// File: rtl/rx_addr_match.sv
// Address comparator.
// Purely combinational: compares a one- or two-octet address with the
// local and remote station addresses and the all-ones global address.
module rx_addr_match
    import rx_addr_screen_pkg::*;
#(
    parameter int OCT_W = 8
) (
    input  logic               [OCT_W-1:0]   oct_lo,
    input  logic               [OCT_W-1:0]   oct_hi,
    input  logic                             two,
    input  logic               [2*OCT_W-1:0] local_addr,
    input  logic               [2*OCT_W-1:0] remote_addr,
    input  scr_mode_t                        mode,
    output logic                             accept,
    output logic                             is_remote,
    output logic                             is_global
);

    logic local_eq;
    logic remote_eq;
    logic glob_eq;

    // Compare octets; the second octet only counts for two-octet fields.
    always_comb begin
        local_eq  = (oct_lo == local_addr[OCT_W-1:0]) &
                    (~two | (oct_hi == local_addr[2*OCT_W-1:OCT_W]));
        remote_eq = (oct_lo == remote_addr[OCT_W-1:0]) &
                    (~two | (oct_hi == remote_addr[2*OCT_W-1:OCT_W]));
        glob_eq   = mode.global_en & (&oct_lo) & (~two | (&oct_hi));
        accept    = mode.promisc | local_eq | remote_eq | glob_eq;
        is_remote = ~mode.promisc & remote_eq & ~local_eq;
        is_global = ~mode.promisc & glob_eq;
    end

endmodule

// File: rtl/rx_sat_counter.sv
// Saturating event counter.
// Adds one per inc pulse and holds at all-ones; cleared by reset.
module rx_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Count events, stopping at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !(&count)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/rx_addr_screen.sv
// Receive address screen (top).
// Decides per received HDLC frame whether the address field targets this
// station, and reports the verdict at the end of the frame. Assumes the
// upstream stage supplies in_good on the final beat and that configuration
// is static during a frame.
module rx_addr_screen
    import rx_addr_screen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_ext_en,
    input  logic                cfg_ext_force,
    input  logic                cfg_global_en,
    input  logic                cfg_promisc,
    input  logic [ADDR_W-1:0]   cfg_local_addr,
    input  logic [ADDR_W-1:0]   cfg_remote_addr,
    input  logic                in_valid,
    input  logic [OCT_W-1:0]    in_data,
    input  logic                in_sof,
    input  logic                in_eof,
    input  logic                in_good,
    output logic                hit_valid,
    output logic                hit_accept,
    output logic                hit_remote,
    output logic                hit_global,
    output logic                hit_two,
    output logic                done_valid,
    output logic                done_keep,
    output logic                done_bad,
    output logic [CNT_W-1:0]    bad_count
);

    scr_mode_t        mode;
    logic             live_beat;
    logic             live_eof;
    logic             addr_done;
    logic             addr_two;
    logic [OCT_W-1:0] oct_lo;
    logic [OCT_W-1:0] oct_hi;
    logic             m_accept;
    logic             m_remote;
    logic             m_global;
    logic             accept_now;
    logic             bad_inc;

    // Gather the mode bits.
    always_comb begin
        mode.ext_en    = cfg_ext_en;
        mode.ext_force = cfg_ext_force;
        mode.global_en = cfg_global_en;
        mode.promisc   = cfg_promisc;
    end

    rx_addr_len_ctl #(.OCT_W(OCT_W)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_vld  (in_valid),
        .beat_sof  (in_sof),
        .beat_eof  (in_eof),
        .beat_data (in_data),
        .ext_en    (mode.ext_en),
        .ext_force (mode.ext_force),
        .live_beat (live_beat),
        .live_eof  (live_eof),
        .addr_done (addr_done),
        .addr_two  (addr_two),
        .oct_lo    (oct_lo),
        .oct_hi    (oct_hi)
    );

    rx_addr_match #(.OCT_W(OCT_W)) u_match (
        .oct_lo      (oct_lo),
        .oct_hi      (oct_hi),
        .two         (addr_two),
        .local_addr  (cfg_local_addr),
        .remote_addr (cfg_remote_addr),
        .mode        (mode),
        .accept      (m_accept),
        .is_remote   (m_remote),
        .is_global   (m_global)
    );

    // Acceptance at the final beat: fresh decision, held one, or bypass.
    always_comb begin
        if (addr_done) begin
            accept_now = m_accept;
        end else if (hit_valid && !(in_valid && in_sof)) begin
            accept_now = hit_accept;
        end else begin
            accept_now = mode.promisc;
        end
        bad_inc = live_eof & ~in_good;
    end

    // Hold the address decision from address end until the next frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid  <= 1'b0;
            hit_accept <= 1'b0;
            hit_remote <= 1'b0;
            hit_global <= 1'b0;
            hit_two    <= 1'b0;
        end else if (addr_done) begin
            hit_valid  <= 1'b1;
            hit_accept <= m_accept;
            hit_remote <= m_remote;
            hit_global <= m_global;
            hit_two    <= addr_two;
        end else if (in_valid && in_sof) begin
            hit_valid  <= 1'b0;
            hit_accept <= 1'b0;
            hit_remote <= 1'b0;
            hit_global <= 1'b0;
            hit_two    <= 1'b0;
        end
    end

    // Issue the one-cycle end-of-frame verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_keep  <= 1'b0;
            done_bad   <= 1'b0;
        end else begin
            done_valid <= live_eof;
            done_keep  <= live_eof & in_good & accept_now;
            done_bad   <= bad_inc;
        end
    end

    rx_sat_counter #(.W(CNT_W)) u_bad_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (bad_inc),
        .count (bad_count)
    );

endmodule

// File: rtl/rx_addr_screen_chk.sv
// Property checker for the receive address screen, bound to the top.
module rx_addr_screen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_ext_en,
    input logic             cfg_ext_force,
    input logic             cfg_promisc,
    input logic             in_valid,
    input logic             in_sof,
    input logic             in_eof,
    input logic             hit_valid,
    input logic             hit_accept,
    input logic             hit_remote,
    input logic             hit_global,
    input logic             hit_two,
    input logic             done_bad,
    input logic [CNT_W-1:0] bad_count
);

    // R9: the counter only ever steps up by one.
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_count != $past(bad_count)) |-> (bad_count == $past(bad_count) + 1'b1));

    // R1: a bad verdict is accompanied by a nonzero count.
    a_r1_bad_counted: assert property (@(posedge clk) disable iff (!rst_n)
        done_bad |-> (bad_count != '0));

    // R5: a remote flag only appears on an accepted decision.
    a_r5_remote_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        hit_remote |-> (hit_valid && hit_accept));

    // R6: a global flag only appears on an accepted decision.
    a_r6_global_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        hit_global |-> (hit_valid && hit_accept));

    // R2: extension off gives a one-octet decision right after the first beat.
    a_r2_single_octet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !cfg_ext_en) |=> (hit_valid && !hit_two));

    // R4: forced extension never decides on the first beat.
    a_r4_force_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !in_eof && cfg_ext_en && cfg_ext_force) |=> !hit_valid);

    // R7: promiscuous one-octet decisions are always accepts.
    a_r7_promisc_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && cfg_promisc && !cfg_ext_en) |=> hit_accept);

endmodule

bind rx_addr_screen rx_addr_screen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_rx_addr_screen.sv
// Directed bench for the receive address screen.
module test_rx_addr_screen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ext_en = 1'b0;
    logic        cfg_ext_force = 1'b0;
    logic        cfg_global_en = 1'b0;
    logic        cfg_promisc = 1'b0;
    logic [15:0] cfg_local_addr = 16'h0;
    logic [15:0] cfg_remote_addr = 16'h0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        in_good = 1'b0;
    logic        hit_valid, hit_accept, hit_remote, hit_global, hit_two;
    logic        done_valid, done_keep, done_bad;
    logic [15:0] bad_count;

    int checks = 0;
    int errors = 0;
    int exp_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rx_addr_screen i_rx_addr_screen (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one beat at a falling edge; return at the next falling edge.
    task automatic beat(input logic [7:0] d, input logic s, input logic e, input logic g);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_good = g;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_good = 1'b0;
    endtask

    task automatic set_mode(input logic ext, input logic frc, input logic glb, input logic prm);
        cfg_ext_en = ext; cfg_ext_force = frc; cfg_global_en = glb; cfg_promisc = prm;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R10 reset hit_valid", hit_valid, 0);
        chk("R10 reset done_valid", done_valid, 0);
        chk("R9 reset count", bad_count, 0);
    endtask

    task automatic t_plain();
        set_mode(0, 0, 0, 0);
        cfg_local_addr = 16'h1142;
        cfg_remote_addr = 16'h2251;
        beat(8'h42, 1, 0, 0);
        chk("R2 one octet valid", hit_valid, 1);
        chk("R2 one octet accept", hit_accept, 1);
        chk("R2 one octet len", hit_two, 0);
        chk("R5 local flag", hit_remote, 0);
        beat(8'h10, 0, 0, 0);
        beat(8'h20, 0, 1, 1);
        chk("R10 done pulse", done_valid, 1);
        chk("R10 done keep", done_keep, 1);
        @(negedge clk);
        chk("R10 done one cycle", done_valid, 0);
        chk("R10 hit held", hit_valid, 1);
    endtask

    task automatic t_ext_rule();
        set_mode(1, 0, 0, 0);
        cfg_local_addr = 16'h2140;
        cfg_remote_addr = 16'h0035;
        beat(8'h40, 1, 0, 0);
        chk("R3 waits second", hit_valid, 0);
        beat(8'h21, 0, 0, 0);
        chk("R3 two valid", hit_valid, 1);
        chk("R3 two len", hit_two, 1);
        chk("R3 two accept", hit_accept, 1);
        beat(8'h00, 0, 1, 1);
        chk("R3 two keep", done_keep, 1);
        beat(8'h35, 1, 0, 0);
        chk("R3 odd one octet", hit_two, 0);
        chk("R5 remote flag", hit_remote, 1);
        beat(8'h00, 0, 1, 1);
        chk("R5 remote keep", done_keep, 1);
    endtask

    task automatic t_force();
        set_mode(1, 1, 0, 0);
        cfg_local_addr = 16'h0000;
        cfg_remote_addr = 16'h7735;
        beat(8'h35, 1, 0, 0);
        chk("R4 forced waits", hit_valid, 0);
        beat(8'h77, 0, 0, 0);
        chk("R4 forced two", hit_two, 1);
        chk("R4 forced accept", hit_accept, 1);
        chk("R4 remote", hit_remote, 1);
        beat(8'h01, 0, 1, 1);
        chk("R4 keep", done_keep, 1);
    endtask

    task automatic t_tie();
        set_mode(0, 0, 0, 0);
        cfg_local_addr = 16'h0066;
        cfg_remote_addr = 16'h0066;
        beat(8'h66, 1, 0, 0);
        chk("R5 tie accept", hit_accept, 1);
        chk("R5 tie local wins", hit_remote, 0);
        beat(8'h00, 0, 1, 1);
    endtask

    task automatic t_global();
        set_mode(0, 0, 1, 0);
        cfg_local_addr = 16'h0001;
        cfg_remote_addr = 16'h0003;
        beat(8'hFF, 1, 0, 0);
        chk("R6 global accept", hit_accept, 1);
        chk("R6 global flag", hit_global, 1);
        beat(8'h00, 0, 1, 1);
        chk("R6 global keep", done_keep, 1);
        set_mode(0, 0, 0, 0);
        beat(8'hFF, 1, 0, 0);
        chk("R6 global off reject", hit_accept, 0);
        chk("R6 global off flag", hit_global, 0);
        beat(8'h00, 0, 1, 1);
        chk("R6 global off drop", done_keep, 0);
    endtask

    task automatic t_nomatch();
        set_mode(0, 0, 0, 0);
        cfg_local_addr = 16'h0001;
        cfg_remote_addr = 16'h0003;
        beat(8'h99, 1, 0, 0);
        chk("R8 decided", hit_valid, 1);
        chk("R8 rejected", hit_accept, 0);
        beat(8'h00, 0, 1, 1);
        chk("R8 done", done_valid, 1);
        chk("R8 not kept", done_keep, 0);
        chk("R8 not bad", done_bad, 0);
        chk("R8 count unchanged", bad_count, exp_bad);
    endtask

    task automatic t_promisc();
        set_mode(0, 0, 0, 1);
        beat(8'h99, 1, 0, 0);
        chk("R7 accept", hit_accept, 1);
        beat(8'h00, 0, 1, 1);
        chk("R7 keep", done_keep, 1);
        set_mode(1, 1, 1, 1);
        beat(8'hFF, 1, 1, 1);
        chk("R7 short kept", done_keep, 1);
        chk("R7 short no decision", hit_valid, 0);
        set_mode(1, 0, 1, 1);
        beat(8'hFF, 1, 0, 0);
        chk("R7 no global flag", hit_global, 0);
        beat(8'h00, 0, 1, 1);
    endtask

    task automatic t_bad();
        set_mode(0, 0, 0, 0);
        cfg_local_addr = 16'h0042;
        beat(8'h42, 1, 0, 0);
        beat(8'h00, 0, 1, 0);
        exp_bad++;
        chk("R1 bad flagged", done_bad, 1);
        chk("R1 bad not kept", done_keep, 0);
        chk("R1 count", bad_count, exp_bad);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 65536; i++) begin
            beat(8'h00, 1, 1, 0);
        end
        chk("R9 saturated", bad_count, 16'hFFFF);
        beat(8'h00, 1, 1, 0);
        chk("R9 held", bad_count, 16'hFFFF);
        do_reset();
        chk("R9 cleared", bad_count, 0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_reset();
        t_plain();
        t_ext_rule();
        t_force();
        t_tie();
        t_global();
        t_nomatch();
        t_promisc();
        t_bad();
        t_saturate();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule